// File: doc/BRIEF.md
# Three-Input Programmable Logic Array with Selectable Registered Outputs

This block is a small programmable sum-of-products device. Three input pins feed an AND plane in which every product term may take the true or inverted form of each pin. A literal joins a term only when its configuration bit is set, and a term with no literals joined reads as 0. Each of the two outputs is the OR of its own pair of product terms. Each output then has a mode bit of its own. With the bit clear, the output follows the logic value directly. With the bit set, the output shows a copy of that value taken by a flip-flop at the previous rising clock edge.

The configuration is 26 bits in total: four 6-bit term masks plus two mode bits. It is written through a parallel port that takes an address, data and a write strobe. A written value replaces the old one at the rising edge where the strobe is seen, and the outputs use the new value from that edge on. Reset clears every configuration bit and every output flip-flop.

For example, the configuration can make output 0 a warning light that is high only when a key is inserted, a passenger is seated and the belt is not fastened.

The design has no state machine. Its state is the configuration store and one flip-flop per output. The only selectable behaviour is each output's mode, which is an enumerated type with two values: `OUT_COMB` and `OUT_REG`.

Top module: `pld_reg_out`

## Requirements
- R1: While reset (`rst_n` low) is applied, and at the first clock edge after it is released, every mask and mode bit is 0 and `pin_o` is 0.
- R2: In a term mask, bit 2i connects the true value of `pin_i[i]` and bit 2i+1 connects its inverse. A term is the AND of all the literals it connects.
- R3: A term whose mask is all zero evaluates to 0. A term that connects both polarities of one pin is always 0.
- R4: Output j is the OR of the terms at addresses 2j and 2j+1.
- R5: A write with `cfg_we` high loads `cfg_data` into term mask k when `cfg_addr` is k (0 to 3). At address 4 it loads `cfg_data[1:0]` as the mode bits, where bit j set means output j is registered. The new value is used from the rising edge at which the write is seen.
- R6: Writes to addresses 5, 6 and 7 change no configuration bit.
- R7: An output whose mode bit is 0 changes with `pin_i` in the same cycle, without waiting for a clock edge.
- R8: An output whose mode bit is 1 shows the logic value that was present at the previous rising clock edge.
- R9: With mask 0x25 at address 0, `pin_o[0]` is `pin_i[0] & pin_i[1] & ~pin_i[2]`. This is the warning condition: key in, seated, belt unfastened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration store and the output flip-flops |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_data | input | 6 | Configuration write data |
| pin_i | input | 3 | Logic inputs |
| pin_o | output | 2 | Logic outputs |

## Verification
The bench builds the block with its default parameters: three inputs, two outputs and two terms per output. With these values the bench can drive all eight input combinations in every output mode. The 3-bit address also gives the bench three unused addresses, at which it checks that writes are ignored. A random phase mixes writes to all eight addresses with input changes in the same cycles, which covers writes that land on the same edge as a registered capture.

// File: rtl/pld_pkg.sv
package pld_pkg;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

endpackage

// File: rtl/pld_cfg_store.sv
module pld_cfg_store #(
    parameter int N_IN          = 3,
    parameter int N_OUT         = 2,
    parameter int TERMS_PER_OUT = 2,
    localparam int MASK_W       = 2 * N_IN,
    localparam int N_TERMS      = N_OUT * TERMS_PER_OUT,
    localparam int N_WORDS      = N_TERMS + 1,
    localparam int ADDR_W       = $clog2(N_WORDS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [MASK_W-1:0]               data_i,
    output logic [N_TERMS-1:0][MASK_W-1:0]  mask_o,
    output logic [N_OUT-1:0]                mode_o
);

    localparam logic [ADDR_W:0] MODE_ADDR = (ADDR_W+1)'(N_TERMS);
    localparam logic [ADDR_W:0] END_ADDR  = (ADDR_W+1)'(N_WORDS);

    logic [N_TERMS-1:0][MASK_W-1:0] mask_q;
    logic [N_OUT-1:0]               mode_q;

    for (genvar k = 0; k < N_TERMS; k++) begin : g_term
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[k] <= '0;
            end else if (we_i && ({1'b0, addr_i} == (ADDR_W+1)'(k))) begin
                mask_q[k] <= data_i;
            end
        end

        // R5: a term write lands in its mask at the next edge
        a_r5_term_load: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && ({1'b0, addr_i} == (ADDR_W+1)'(k))) |=> (mask_q[k] == $past(data_i)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (we_i && ({1'b0, addr_i} == MODE_ADDR)) begin
            mode_q <= data_i[N_OUT-1:0];
        end
    end

    assign mask_o = mask_q;
    assign mode_o = mode_q;

    // R6: unused addresses leave the whole store untouched
    a_r6_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && ({1'b0, addr_i} >= END_ADDR)) |=> ($stable(mask_q) && $stable(mode_q)));

endmodule

// File: rtl/pld_and_plane.sv
module pld_and_plane #(
    parameter int N_IN     = 3,
    parameter int N_TERMS  = 4,
    localparam int MASK_W  = 2 * N_IN
) (
    input  logic [N_IN-1:0]                 pin_i,
    input  logic [N_TERMS-1:0][MASK_W-1:0]  mask_i,
    output logic [N_TERMS-1:0]              term_o
);

    logic [MASK_W-1:0] lit;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i]   = pin_i[i];
        assign lit[2*i+1] = ~pin_i[i];
    end

    for (genvar k = 0; k < N_TERMS; k++) begin : g_term
        logic any_conn;
        logic all_true;
        assign any_conn  = |mask_i[k];
        assign all_true  = &(lit | ~mask_i[k]);
        assign term_o[k] = any_conn & all_true;

        // R3: a term tied to both polarities of one pin never fires
        for (genvar i = 0; i < N_IN; i++) begin : g_contra
            always_comb begin
                if (mask_i[k][2*i] && mask_i[k][2*i+1]) begin
                    a_r3_contradiction: assert (!term_o[k]);
                end
            end
        end
    end

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
    import pld_pkg::*;
#(
    parameter int TERMS_PER_OUT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TERMS_PER_OUT-1:0] term_i,
    input  out_mode_e                mode_i,
    output logic                     out_o
);

    logic sum;
    logic cap_q;

    assign sum = |term_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
        end else begin
            cap_q <= sum;
        end
    end

    always_comb begin
        unique case (mode_i)
            OUT_COMB: out_o = sum;
            OUT_REG:  out_o = cap_q;
            default:  out_o = sum;
        endcase
    end

    // R8: a registered output shows the value present one edge earlier
    a_r8_reg_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OUT_REG) |-> (out_o == $past(sum)));

endmodule

// File: rtl/pld_reg_out.sv
module pld_reg_out
    import pld_pkg::*;
#(
    parameter int N_IN          = 3,
    parameter int N_OUT         = 2,
    parameter int TERMS_PER_OUT = 2,
    localparam int MASK_W       = 2 * N_IN,
    localparam int N_TERMS      = N_OUT * TERMS_PER_OUT,
    localparam int ADDR_W       = $clog2(N_TERMS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [MASK_W-1:0] cfg_data,
    input  logic [N_IN-1:0]   pin_i,
    output logic [N_OUT-1:0]  pin_o
);

    logic [N_TERMS-1:0][MASK_W-1:0] mask;
    logic [N_OUT-1:0]               mode;
    logic [N_TERMS-1:0]             term;

    pld_cfg_store #(
        .N_IN          (N_IN),
        .N_OUT         (N_OUT),
        .TERMS_PER_OUT (TERMS_PER_OUT)
    ) cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we),
        .addr_i (cfg_addr),
        .data_i (cfg_data),
        .mask_o (mask),
        .mode_o (mode)
    );

    pld_and_plane #(
        .N_IN    (N_IN),
        .N_TERMS (N_TERMS)
    ) plane_i (
        .pin_i  (pin_i),
        .mask_i (mask),
        .term_o (term)
    );

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        pld_out_cell #(
            .TERMS_PER_OUT (TERMS_PER_OUT)
        ) cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .term_i (term[j*TERMS_PER_OUT +: TERMS_PER_OUT]),
            .mode_i (out_mode_e'(mode[j])),
            .out_o  (pin_o[j])
        );
    end

    // R1: the first edge after reset sees a cleared device
    a_r1_clear_out: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_o == '0));

endmodule

// File: tb/pld_reg_out_tb_top.sv
module pld_reg_out_tb_top;

    localparam int N_IN   = 3;
    localparam int N_OUT  = 2;
    localparam int TPO    = 2;
    localparam int MASK_W = 2 * N_IN;
    localparam int N_TERMS = N_OUT * TPO;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [MASK_W-1:0] cfg_data = '0;
    logic [N_IN-1:0]   pin_i = '0;
    logic [N_OUT-1:0]  pin_o;

    int checks = 0;
    int fails  = 0;

    logic [MASK_W-1:0] sh_mask [N_TERMS];
    logic [N_OUT-1:0]  sh_mode;
    logic [N_OUT-1:0]  exp_cap;

    always #10 clk = ~clk;

    pld_reg_out dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .pin_i    (pin_i),
        .pin_o    (pin_o)
    );

    function automatic logic term_val(int k, logic [N_IN-1:0] p);
        logic r;
        if (sh_mask[k] == '0) return 1'b0;
        r = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            if (sh_mask[k][2*i]   && !p[i]) r = 1'b0;
            if (sh_mask[k][2*i+1] &&  p[i]) r = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [N_OUT-1:0] logic_val(logic [N_IN-1:0] p);
        logic [N_OUT-1:0] r;
        for (int j = 0; j < N_OUT; j++) begin
            r[j] = 1'b0;
            for (int t = 0; t < TPO; t++) r[j] = r[j] | term_val(j*TPO + t, p);
        end
        return r;
    endfunction

    function automatic logic [N_OUT-1:0] exp_out(logic [N_IN-1:0] p);
        logic [N_OUT-1:0] c;
        c = logic_val(p);
        return (sh_mode & exp_cap) | (~sh_mode & c);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_TERMS; k++) sh_mask[k] <= '0;
            sh_mode <= '0;
            exp_cap <= '0;
        end else begin
            exp_cap <= logic_val(pin_i);
            if (cfg_we) begin
                if (cfg_addr < 3'(N_TERMS)) sh_mask[cfg_addr] <= cfg_data;
                else if (cfg_addr == 3'(N_TERMS)) sh_mode <= cfg_data[N_OUT-1:0];
            end
        end
    end

    task automatic check(string tag, logic [N_OUT-1:0] expv);
        checks++;
        if (pin_o !== expv) begin
            fails++;
            $display("FAIL %s: pin_i=%b actual=%b expected=%b", tag, pin_i, pin_o, expv);
        end
    endtask

    task automatic step(logic we, logic [ADDR_W-1:0] a, logic [MASK_W-1:0] d,
                        logic [N_IN-1:0] p, string tag);
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_data = d; pin_i = p;
        #5 check(tag, exp_out(pin_i));
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [MASK_W-1:0] d);
        step(1'b1, a, d, pin_i, "R5 write");
        step(1'b0, '0, '0, pin_i, "R5 after write");
    endtask

    task automatic sweep(string tag);
        for (int v = 0; v < 8; v++) step(1'b0, '0, '0, 3'(v), tag);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        pin_i = 3'b111;
        repeat (3) @(posedge clk);
        #5 check("R1 in reset", 2'b00);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #5 check("R1 first edge", 2'b00);

        sweep("R3 empty terms");
        wr(3'd0, 6'h25);
        sweep("R9 warning R7 comb");
        for (int v = 0; v < 8; v++) begin
            step(1'b0, '0, '0, 3'(v), "R9 direct");
            check("R9 direct value", {1'b0, (v[0] & v[1] & ~v[2]) ? 1'b1 : 1'b0});
        end
        wr(3'd1, 6'h03);
        sweep("R3 contradiction");
        wr(3'd2, 6'h02);
        wr(3'd3, 6'h14);
        sweep("R4 R2 two terms");
        for (int a = 5; a < 8; a++) wr(3'(a), 6'h3F);
        sweep("R6 unused address");
        wr(3'd4, 6'h03);
        sweep("R8 registered");
        @(negedge clk) pin_i = 3'b011;
        @(negedge clk) pin_i = 3'b111;
        #5 check("R8 lag before edge", 2'b01);
        @(posedge clk); #5 check("R8 lag after edge", 2'b10);
        wr(3'd4, 6'h01);
        sweep("R7 R8 mixed modes");
        for (int n = 0; n < 400; n++) begin
            step(($urandom % 3) == 0, 3'($urandom % 8), 6'($urandom),
                 3'($urandom), "R2 R5 random");
        end
        @(negedge clk) rst_n = 1'b0; cfg_we = 1'b0;
        #5 check("R1 mid-run reset", 2'b00);
        @(negedge clk) rst_n = 1'b1;
        sweep("R1 R3 cleared after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule